// File: doc/BRIEF.md
# Two-Level DMA Channel Arbiter

This block chooses which of 32 DMA channel request lines is served next and grants one channel at a time. Every channel has a priority-class bit that software raises and lowers through separate write-one ports. A channel whose bit is raised beats every channel whose bit is low. Within a class, the lower channel number wins.

Each channel also stores a burst-size exponent. Once a channel is granted, it keeps the grant for 2^exp item transfers. The transfer engine reports each item with a strobe. The grant is then released, and re-arbitration happens on the following cycle. A higher-priority request that arrives during a burst waits for the burst to end. The burst also ends early if the granted channel withdraws its request.

Top module: `dma_chan_arb`

## Requirements
- R1: After reset, `gnt_valid` is 0, `prio_rd` is all zeros and every channel's burst exponent is 0, so a burst is one item long.
- R2: When `gnt_valid` is 0 at a clock edge and at least one `req` bit is 1, the winner is granted at that edge: `gnt_valid` becomes 1 and `gnt_idx` holds the winner. With `req` all zeros, `gnt_valid` stays 0.
- R3: Among requesting channels whose priority bit is 0, and when no requesting channel has its bit set, the lowest channel number wins.
- R4: A requesting channel whose priority bit is 1 beats every channel whose bit is 0. Among several such channels, the lowest number wins.
- R5: A cycle with `prio_set_we`=1 sets the priority bit of every channel whose position in `prio_set_data` is 1. A cycle with `prio_clr_we`=1 clears the bit of every channel whose position in `prio_clr_data` is 1. Positions written 0 are unchanged. Bit i of `prio_rd` shows channel i's bit from the next cycle on.
- R6: If the same bit is both set and cleared in one cycle, clearing wins.
- R7: A cycle with `size_we`=1 stores `size_exp` as the exponent of channel `size_sel`. A grant lasts 2^exp item pulses (`item_done`=1 at an edge while granted). Exponents above 10 give 1024. At the edge that takes the last item, `gnt_valid` falls.
- R8: While `gnt_valid` stays 1, `gnt_idx` does not change, even if a higher-priority channel requests. A waiting request is granted at the edge after the burst ends.
- R9: If the granted channel's `req` bit is 0 at an edge, `gnt_valid` falls at that edge, whatever the remaining count is.
- R10: `item_done` pulses while `gnt_valid` is 0 have no effect on the length of the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 32 | Per-channel request lines |
| item_done | input | 1 | One item of the current burst was transferred |
| prio_set_we | input | 1 | Write strobe of the priority set port |
| prio_set_data | input | 32 | Write-one mask of bits to set |
| prio_clr_we | input | 1 | Write strobe of the priority clear port |
| prio_clr_data | input | 32 | Write-one mask of bits to clear |
| size_we | input | 1 | Write strobe for a burst exponent |
| size_sel | input | 5 | Channel whose exponent is written |
| size_exp | input | 4 | Burst exponent, length is 2^exp capped at 1024 |
| gnt_idx | output | 5 | Granted channel number |
| gnt_valid | output | 1 | A channel holds the grant |
| prio_rd | output | 32 | Current priority bits |

## Verification
A grant, a release and a priority write all appear one clock edge after the stimulus that causes them. A burst of n items releases the grant at the edge that takes the n-th item, and a waiting channel is granted one edge later. The bench changes its inputs 1 time unit after a rising edge and samples the outputs at that same point, after the edge the result is due on. It counts burst lengths edge by edge against 2^exp, capped at 1024, which it computes itself.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int EXP_W   = 4;
  localparam int MAX_EXP = 10;
  localparam int LEN_W   = MAX_EXP + 1;
  localparam logic [EXP_W-1:0] MAX_EXP_V = EXP_W'(MAX_EXP);

  // burst length in items for a stored exponent, saturating at 2^MAX_EXP
  function automatic logic [LEN_W-1:0] burst_len(input logic [EXP_W-1:0] e);
    logic [LEN_W-1:0] one;
    one = LEN_W'(1);
    if (e > MAX_EXP_V) return one << MAX_EXP;
    return one << e;
  endfunction
endpackage

// File: rtl/dma_prio_regs.sv
module dma_prio_regs #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_we,
  input  logic [NCH-1:0] set_mask,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] prio_q
);
  logic [NCH-1:0] set_eff, clr_eff;

  assign set_eff = set_we ? set_mask : '0;
  assign clr_eff = clr_we ? clr_mask : '0;

  // clear dominates a simultaneous set of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else        prio_q <= (prio_q | set_eff) & ~clr_eff;
  end
endmodule

// File: rtl/dma_size_regs.sv
module dma_size_regs #(
  parameter int NCH   = 32,
  parameter int EXP_W = 4,
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_sel,
  input  logic [EXP_W-1:0] wr_exp,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [EXP_W-1:0] rd_exp
);
  logic [EXP_W-1:0] exp_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            exp_q[g] <= '0;
      else if (we && wr_sel == IDX_W'(g))    exp_q[g] <= wr_exp;
    end
  end

  assign rd_exp = exp_q[rd_sel];
endmodule

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int NCH       = 32,
  parameter bit TWO_LEVEL = 1'b1,
  localparam int IDX_W    = $clog2(NCH)
) (
  input  logic [NCH-1:0]   req,
  input  logic [NCH-1:0]   prio,
  output logic             any,
  output logic             win_hi,
  output logic [IDX_W-1:0] win_idx
);
  logic [NCH-1:0] hi_req, cand;

  // lowest set position; channel 0 ranks first
  function automatic logic [IDX_W-1:0] first_set(input logic [NCH-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign hi_req = req & prio;
  assign any    = |req;

  if (TWO_LEVEL) begin : g_two
    assign win_hi = |hi_req;
    assign cand   = win_hi ? hi_req : req;
  end else begin : g_flat
    assign win_hi = 1'b0;
    assign cand   = req;
  end

  assign win_idx = first_set(cand);
endmodule

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl #(
  parameter int NCH   = 32,
  parameter int LEN_W = 11,
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [LEN_W-1:0] win_len,
  input  logic             owner_req,
  input  logic             item_done,
  output logic             gnt_valid,
  output logic [IDX_W-1:0] gnt_idx,
  output logic [LEN_W-1:0] count_q,
  output logic             grant_load,
  output logic             burst_end
);
  logic last_item, owner_gone;

  assign grant_load = !gnt_valid && any;
  assign last_item  = gnt_valid && item_done && (count_q == LEN_W'(1));
  assign owner_gone = gnt_valid && !owner_req;
  assign burst_end  = last_item || owner_gone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_idx   <= '0;
      count_q   <= '0;
    end else if (grant_load) begin
      gnt_valid <= 1'b1;
      gnt_idx   <= win_idx;
      count_q   <= win_len;
    end else if (burst_end) begin
      gnt_valid <= 1'b0;
      count_q   <= '0;
    end else if (gnt_valid && item_done) begin
      count_q   <= count_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb #(
  parameter int NCH = 32,
  localparam int IDX_W = $clog2(NCH),
  localparam int EXP_W = dma_arb_pkg::EXP_W,
  localparam int LEN_W = dma_arb_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req,
  input  logic             item_done,
  input  logic             prio_set_we,
  input  logic [NCH-1:0]   prio_set_data,
  input  logic             prio_clr_we,
  input  logic [NCH-1:0]   prio_clr_data,
  input  logic             size_we,
  input  logic [IDX_W-1:0] size_sel,
  input  logic [EXP_W-1:0] size_exp,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_valid,
  output logic [NCH-1:0]   prio_rd
);
  logic             any_req, win_hi;
  logic [IDX_W-1:0] win_idx;
  logic [EXP_W-1:0] win_exp;
  logic [LEN_W-1:0] win_len;
  logic [LEN_W-1:0] count_q;
  logic             grant_load, burst_end, owner_req;

  dma_prio_regs #(.NCH(NCH)) u_prio (
    .clk(clk), .rst_n(rst_n),
    .set_we(prio_set_we), .set_mask(prio_set_data),
    .clr_we(prio_clr_we), .clr_mask(prio_clr_data),
    .prio_q(prio_rd)
  );

  dma_size_regs #(.NCH(NCH), .EXP_W(EXP_W)) u_size (
    .clk(clk), .rst_n(rst_n),
    .we(size_we), .wr_sel(size_sel), .wr_exp(size_exp),
    .rd_sel(win_idx), .rd_exp(win_exp)
  );

  dma_pick #(.NCH(NCH), .TWO_LEVEL(1'b1)) u_pick (
    .req(req), .prio(prio_rd),
    .any(any_req), .win_hi(win_hi), .win_idx(win_idx)
  );

  assign win_len   = dma_arb_pkg::burst_len(win_exp);
  assign owner_req = req[gnt_idx];

  dma_burst_ctl #(.NCH(NCH), .LEN_W(LEN_W)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .any(any_req), .win_idx(win_idx), .win_len(win_len),
    .owner_req(owner_req), .item_done(item_done),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .count_q(count_q),
    .grant_load(grant_load), .burst_end(burst_end)
  );
endmodule

// File: rtl/dma_chan_arb_chk.sv
module dma_chan_arb_chk #(
  parameter int NCH = 32,
  localparam int IDX_W = $clog2(NCH),
  localparam int LEN_W = dma_arb_pkg::LEN_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   req,
  input logic             item_done,
  input logic             prio_set_we,
  input logic [NCH-1:0]   prio_set_data,
  input logic             prio_clr_we,
  input logic [NCH-1:0]   prio_clr_data,
  input logic [NCH-1:0]   prio_rd,
  input logic             gnt_valid,
  input logic [IDX_W-1:0] gnt_idx,
  input logic [LEN_W-1:0] count_q,
  input logic             grant_load,
  input logic             burst_end,
  input logic             win_hi
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(1) << dma_arb_pkg::MAX_EXP;

  // R2
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && req != '0) |=> gnt_valid);

  // R2
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && req == '0) |=> !gnt_valid);

  // R8
  hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !burst_end) |=> (gnt_valid && gnt_idx == $past(gnt_idx)));

  // R9
  drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !req[gnt_idx]) |=> !gnt_valid);

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (count_q != '0 && count_q <= LEN_CAP));

  // R7
  item_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && item_done && !burst_end) |=> (count_q == $past(count_q) - LEN_W'(1)));

  // R5
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_set_we && !prio_clr_we) |=> ((prio_rd & $past(prio_set_data)) == $past(prio_set_data)));

  // R6
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prio_clr_we |=> ((prio_rd & $past(prio_clr_data)) == '0));

  // R4
  hi_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_load && win_hi && !prio_clr_we) |=> prio_rd[gnt_idx]);

  // R10
  idle_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && item_done && req == '0) |=> (!gnt_valid && count_q == '0));
endmodule

bind dma_chan_arb dma_chan_arb_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .item_done(item_done),
  .prio_set_we(prio_set_we), .prio_set_data(prio_set_data),
  .prio_clr_we(prio_clr_we), .prio_clr_data(prio_clr_data),
  .prio_rd(prio_rd), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
  .count_q(count_q), .grant_load(grant_load), .burst_end(burst_end),
  .win_hi(win_hi)
);

// File: tb/sim_dma_chan_arb.sv
module sim_dma_chan_arb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] req;
  logic        item_done;
  logic        prio_set_we, prio_clr_we, size_we;
  logic [31:0] prio_set_data, prio_clr_data;
  logic [4:0]  size_sel;
  logic [3:0]  size_exp;
  logic [4:0]  gnt_idx;
  logic        gnt_valid;
  logic [31:0] prio_rd;

  int checks = 0;
  int errors = 0;

  dma_chan_arb u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .item_done(item_done),
    .prio_set_we(prio_set_we), .prio_set_data(prio_set_data),
    .prio_clr_we(prio_clr_we), .prio_clr_data(prio_clr_data),
    .size_we(size_we), .size_sel(size_sel), .size_exp(size_exp),
    .gnt_idx(gnt_idx), .gnt_valid(gnt_valid), .prio_rd(prio_rd)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_len(input int e);
    return (e > 10) ? 1024 : (1 << e);
  endfunction

  task automatic write_prio(input bit sw, input logic [31:0] sd, input bit cw, input logic [31:0] cd);
    prio_set_we = sw; prio_set_data = sd;
    prio_clr_we = cw; prio_clr_data = cd;
    tick();
    prio_set_we = 1'b0; prio_clr_we = 1'b0;
    prio_set_data = '0; prio_clr_data = '0;
  endtask

  task automatic write_size(input int ch, input int e);
    size_we = 1'b1; size_sel = 5'(ch); size_exp = 4'(e);
    tick();
    size_we = 1'b0;
  endtask

  // grant-valid and index expected after the next edge
  task automatic expect_grant(input string rq, input int ch);
    check(gnt_valid === 1'b1 && gnt_idx === 5'(ch), rq, {gnt_valid, gnt_idx}, {1'b1, 5'(ch)});
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; item_done = 1'b0;
    prio_set_we = 1'b0; prio_clr_we = 1'b0; prio_set_data = '0; prio_clr_data = '0;
    size_we = 1'b0; size_sel = '0; size_exp = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check(gnt_valid === 1'b0, "R1 valid", gnt_valid, 0);
    check(prio_rd === 32'h0, "R1 prio", prio_rd, 0);
    // R1 default exponent 0: one item per burst
    req = 32'h1 << 7;
    tick();
    expect_grant("R1 grant", 7);
    item_done = 1'b1;
    tick();
    check(gnt_valid === 1'b0, "R1 one-item burst", gnt_valid, 0);
    item_done = 1'b0; req = '0;
    tick();

    // R2 no requests keeps idle
    tick();
    check(gnt_valid === 1'b0, "R2 idle", gnt_valid, 0);

    // R2 / R9 every channel alone, then withdraw
    for (int c = 0; c < 32; c++) begin
      req = 32'h1 << c;
      tick();
      expect_grant("R2 single", c);
      req = '0;
      tick();
      check(gnt_valid === 1'b0, "R9 withdraw", gnt_valid, 0);
    end

    // R3 lowest number wins in default class
    for (int c = 0; c < 31; c++) begin
      req = (32'h1 << c) | (32'h1 << (c + 1)) | 32'h8000_0000;
      tick();
      expect_grant("R3 fixed order", c);
      req = '0;
      tick();
    end

    // R5 / R6 / R4 one high channel at a time, all channels requesting
    for (int h = 1; h < 32; h++) begin
      write_prio(1'b1, 32'h1 << h, 1'b1, ~(32'h1 << h));
      check(prio_rd === (32'h1 << h), "R5 single high bit", prio_rd, 32'h1 << h);
      req = 32'hFFFF_FFFF;
      tick();
      expect_grant("R4 high beats low", h);
      req = '0;
      tick();
    end

    // R4 lowest among several high channels
    write_prio(1'b1, (32'h1 << 20) | (32'h1 << 25), 1'b1, 32'hFFFF_FFFF & ~((32'h1 << 20) | (32'h1 << 25)));
    req = (32'h1 << 3) | (32'h1 << 20) | (32'h1 << 25);
    tick();
    expect_grant("R4 two high", 20);
    req = '0; tick();
    req = (32'h1 << 3) | (32'h1 << 25);
    tick();
    expect_grant("R4 one high", 25);
    req = '0; tick();

    // R5 write-one set and clear, zeros leave bits alone
    write_prio(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
    check(prio_rd === 32'h0, "R5 clear all", prio_rd, 0);
    write_prio(1'b1, 32'h0000_00F0, 1'b0, '0);
    check(prio_rd === 32'h0000_00F0, "R5 set", prio_rd, 32'hF0);
    write_prio(1'b1, 32'h0, 1'b1, 32'h0);
    check(prio_rd === 32'h0000_00F0, "R5 zeros no effect", prio_rd, 32'hF0);
    write_prio(1'b0, '0, 1'b1, 32'h0000_0030);
    check(prio_rd === 32'h0000_00C0, "R5 clear", prio_rd, 32'hC0);
    // R6 clear wins on a shared bit
    write_prio(1'b1, 32'h0000_0300, 1'b1, 32'h0000_0100);
    check(prio_rd === 32'h0000_02C0, "R6 clear wins", prio_rd, 32'h2C0);
    write_prio(1'b0, '0, 1'b1, 32'hFFFF_FFFF);

    // R7 / R8 burst length per exponent, higher request waits
    for (int e = 0; e < 12; e++) begin
      int n;
      bit held;
      write_size(5, e);
      req = 32'h1 << 5;
      tick();
      expect_grant("R7 grant", 5);
      req = (32'h1 << 5) | (32'h1 << 2);
      item_done = 1'b1;
      n = 0; held = 1'b1;
      do begin
        tick();
        n++;
        if (gnt_valid && gnt_idx !== 5'd5) held = 1'b0;
      end while (gnt_valid && n < 2000);
      item_done = 1'b0;
      check(n == exp_len(e), "R7 burst length", n, exp_len(e));
      check(held, "R8 no preemption", held, 1);
      tick();
      expect_grant("R8 waiter served", 2);
      req = '0;
      tick();
    end

    // R10 idle item pulses ignored
    write_size(9, 2);
    item_done = 1'b1;
    repeat (3) tick();
    check(gnt_valid === 1'b0, "R10 idle", gnt_valid, 0);
    item_done = 1'b0;
    req = 32'h1 << 9;
    tick();
    expect_grant("R10 grant", 9);
    begin
      int n;
      item_done = 1'b1;
      n = 0;
      do begin
        tick();
        n++;
      end while (gnt_valid && n < 100);
      item_done = 1'b0;
      check(n == 4, "R10 burst length after idle pulses", n, 4);
    end
    req = '0;
    tick();

    // R9 withdraw mid-burst
    req = 32'h1 << 9;
    tick();
    expect_grant("R9 grant", 9);
    item_done = 1'b1;
    repeat (2) tick();
    check(gnt_valid === 1'b1, "R9 still held", gnt_valid, 1);
    item_done = 1'b0;
    req = '0;
    tick();
    check(gnt_valid === 1'b0, "R9 early end", gnt_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule